// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Idle Control

This block is a system-monitor watchdog for a small 8-bit controller. It counts oscillator clocks through three stages: a machine-cycle divider (twelve clocks by default), a prescaler of 2 to 256 picked by a 3-bit code, and a 2^14 main counter. Firmware restarts the count at regular intervals through a software clear. If the main counter wraps before firmware clears it, the block sets a sticky time-out flag and sends a one-clock reset request to the chip's reset logic.

A single byte-wide control register holds the run enable, the self-clearing clear command, the choice of running or freezing while the core is idle, and the prescaler code. The same register read back also shows the time-out flag. A new prescaler code is held back until the next clear, so firmware cannot shorten the period it is already in.

Top module: `wdt_timer`

## Requirements
- R1: After reset the register reads 0x00, the time-out flag and reset request are 0, and the watchdog does not count until bit 7 (enable) is written 1.
- R2: Register layout: bit 7 is enable, bit 5 is run-in-idle, bits 2:0 are the prescaler code, and bit 4 reads the time-out flag. Bits 6 and 3 always read 0. Writes to bits 4 and 3 have no effect.
- R3: A write with bit 6 set zeroes the machine-cycle divider, the prescaler, the main counter and the time-out flag. Bit 6 is not stored.
- R4: The prescaler code maps 000→2, 010→4, 001→8, 011→16, 100→32, 101→64, 110→128, 111→256. A time-out comes after 2^CNT_W × prescale × MC_DIV counted clocks since the last clear.
- R5: While bit 5 is 0 and the idle input is 1, no clock is counted.
- R6: While bit 5 is 1, counting continues with the idle input at 1.
- R7: On a time-out the flag is set and stays set until a clear, and the reset request is high for exactly one clock.
- R8: Writing bit 7 to 0 stops counting but keeps the count reached; enabling again without a clear resumes from there.
- R9: A prescaler code written without bit 6 shows on read-back but is used only from the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| idle | input | 1 | Core is in idle mode |
| tmo_flag | output | 1 | Sticky time-out flag |
| rst_req | output | 1 | One-clock system reset request |

## Verification
A write takes effect at the clock edge that samples it, and the first counted clock is the edge after that. The reset request and flag therefore go high right after the N-th counted edge following the write, where N = 2^CNT_W × prescale × MC_DIV. The bench drives all inputs on falling edges and counts edges from the write. For every period it checks the request low after edge N-1, high after edge N and low again after edge N+1. When idle or disabled windows are inserted, the edges they cover are left out of the count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W = 3;
  localparam int PS_W  = 8;   // largest prescale is 2^PS_W
  typedef logic [SEL_W-1:0] psel_t;

  // log2 of the prescale ratio; the code is not monotonic in its low bits
  function automatic logic [3:0] psel_shift(input psel_t s);
    if (s[2]) return 4'd5 + {2'b00, s[1:0]};
    else      return 4'd1 + {2'b00, s[0], s[1]};
  endfunction
endpackage

// File: rtl/wdt_mcycle.sv
module wdt_mcycle #(
  parameter int MC_DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic mc_tick
);
  generate
    if (MC_DIV <= 1) begin : g_direct
      assign mc_tick = run & ~clr;
    end else begin : g_count
      localparam int MC_W = $clog2(MC_DIV);
      localparam logic [MC_W-1:0] MC_LAST = MC_W'(MC_DIV - 1);
      logic [MC_W-1:0] mc_cnt;

      assign mc_tick = run & ~clr & (mc_cnt == MC_LAST);

      always_ff @(posedge clk) begin
        if (rst || clr)   mc_cnt <= '0;
        else if (mc_tick) mc_cnt <= '0;
        else if (run)     mc_cnt <= mc_cnt + 1'b1;
      end

      AST_MC_RANGE: assert property (@(posedge clk) disable iff (rst)
        mc_cnt <= MC_LAST); // R4
    end
  endgenerate
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clr,
  input  psel_t new_sel,
  input  logic  mc_tick,
  output logic  ps_tick
);
  psel_t           act_sel;
  logic [PS_W-1:0] ps_cnt;
  logic [PS_W-1:0] ps_last;

  assign ps_last = ~({PS_W{1'b1}} << psel_shift(act_sel));
  assign ps_tick = mc_tick & (ps_cnt == ps_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel <= '0;
      ps_cnt  <= '0;
    end else if (clr) begin
      act_sel <= new_sel;
      ps_cnt  <= '0;
    end else if (ps_tick) begin
      ps_cnt  <= '0;
    end else if (mc_tick) begin
      ps_cnt  <= ps_cnt + 1'b1;
    end
  end

  AST_PS_RANGE: assert property (@(posedge clk) disable iff (rst)
    ps_cnt <= ps_last); // R4
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    !clr |=> $stable(act_sel)); // R9
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic ps_tick,
  output logic wrap
);
  logic [CNT_W-1:0] cnt;

  assign wrap = ps_tick & (&cnt);

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (ps_tick) cnt <= cnt + 1'b1;
  end

  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(cnt)); // R5
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int MC_DIV = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       idle,
  output logic       tmo_flag,
  output logic       rst_req
);
  logic  en_q, idle_run_q, tmo_q, req_q;
  psel_t sel_q;
  logic  clr, run, mc_tick, ps_tick, wrap;
  logic  unused_bits;

  assign unused_bits = ^wr_data[4:3];
  assign clr = wr_en & wr_data[6];
  assign run = en_q & (~idle | idle_run_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      idle_run_q <= 1'b0;
      sel_q      <= '0;
    end else if (wr_en) begin
      en_q       <= wr_data[7];
      idle_run_q <= wr_data[5];
      sel_q      <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      tmo_q <= clr ? 1'b0 : (tmo_q | wrap);
      req_q <= wrap;
    end
  end

  wdt_mcycle #(.MC_DIV(MC_DIV)) u_mc (
    .clk(clk), .rst(rst), .clr(clr), .run(run), .mc_tick(mc_tick));

  wdt_prescale u_ps (
    .clk(clk), .rst(rst), .clr(clr), .new_sel(wr_data[2:0]),
    .mc_tick(mc_tick), .ps_tick(ps_tick));

  wdt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr), .run(run),
    .ps_tick(ps_tick), .wrap(wrap));

  assign rd_data  = {en_q, 1'b0, idle_run_q, tmo_q, 1'b0, sel_q};
  assign tmo_flag = tmo_q;
  assign rst_req  = req_q;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req); // R7
  AST_REQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> tmo_flag); // R7
  AST_CLR_FLAG: assert property (@(posedge clk) disable iff (rst)
    clr |=> !tmo_flag); // R3
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !rst_req); // R1
endmodule

// File: tb/sim_wdt_timer.sv
module sim_wdt_timer;
  localparam int CW = 4;
  localparam int MD = 3;
  localparam int BASE = (1 << CW) * MD;

  logic       clk = 1'b0;
  logic       rst, wr_en, idle;
  logic [7:0] wr_data, rd_data;
  logic       tmo_flag, rst_req;
  int         total = 0, bad = 0;
  logic       done = 1'b0;

  // {prescaler code, expected ratio}
  localparam logic [11:0] VEC [8] = '{
    {3'b000, 9'd2},   {3'b010, 9'd4},  {3'b001, 9'd8},   {3'b011, 9'd16},
    {3'b100, 9'd32},  {3'b101, 9'd64}, {3'b110, 9'd128}, {3'b111, 9'd256}};

  always #2 clk = ~clk;

  wdt_timer #(.CNT_W(CW), .MC_DIV(MD)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .idle(idle), .tmo_flag(tmo_flag), .rst_req(rst_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // after the write edge, expect the request exactly n counted edges later
  task automatic expect_tmo(input string req, input int n);
    wait_n(n - 1);
    chk(req, rst_req, 1'b0);
    wait_n(1);
    chk(req, rst_req, 1'b1);
    chk(req, tmo_flag, 1'b1);
    wait_n(1);
    chk(req, rst_req, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00; idle = 1'b0;
    wait_n(3);
    rst = 1'b0;
    chk("R1 reset reg", rd_data, 8'h00);
    chk("R1 reset flag", tmo_flag, 1'b0);
    chk("R1 reset req", rst_req, 1'b0);

    // disabled: clear only, no counting
    wr(8'h40);
    chk("R3 clear bit reads 0", rd_data, 8'h00);
    wait_n(300);
    chk("R1 disabled no flag", tmo_flag, 1'b0);

    // table walk: every prescaler code
    for (int i = 0; i < 8; i++) begin
      wr({5'b11000, VEC[i][11:9]});
      chk("R2 sel readback", rd_data[2:0], VEC[i][11:9]);
      expect_tmo("R4 R7 period", BASE * int'(VEC[i][8:0]));
    end

    wait_n(10);
    chk("R7 sticky flag", rd_data[4], 1'b1);
    wr(8'h40);
    chk("R3 clear drops flag", tmo_flag, 1'b0);
    wr(8'h18);
    chk("R2 bits 4,3 ignored", rd_data, 8'h00);

    // idle freeze
    wr(8'hC0);
    wait_n(40);
    idle = 1'b1;
    wait_n(50);
    chk("R5 frozen no req", rst_req, 1'b0);
    idle = 1'b0;
    expect_tmo("R5 idle freeze", 56);

    // run through idle
    idle = 1'b1;
    wr(8'hE0);
    expect_tmo("R6 idle run", 2 * BASE);
    idle = 1'b0;

    // clear mid-way restarts
    wr(8'hC0);
    wait_n(59);
    wr(8'hC0);
    wait_n(36);
    chk("R3 old deadline gone", rst_req, 1'b0);
    chk("R3 old deadline flag", tmo_flag, 1'b0);
    expect_tmo("R3 restart", 2 * BASE - 36);

    // disable keeps count
    wr(8'hC0);
    wait_n(49);
    wr(8'h00);
    wait_n(30);
    chk("R8 disabled flag", tmo_flag, 1'b0);
    wr(8'h80);
    expect_tmo("R8 resume", 2 * BASE - 50);

    // new code waits for clear
    wr(8'hC0);
    wait_n(9);
    wr(8'hA7);
    chk("R9 readback", rd_data, 8'hA7);
    expect_tmo("R9 old ratio kept", 2 * BASE - 10);

    // reset mid-run
    wr(8'hC1);
    wait_n(20);
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    chk("R1 reset mid-run reg", rd_data, 8'h00);
    wait_n(3 * BASE);
    chk("R1 reset mid-run req", tmo_flag, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule